// File: doc/BRIEF.md
# Runahead Checkpoint and Poison Tracker

This block decides when a core is pre-executing past a long-latency load miss and keeps the register state needed to undo that pre-execution. When the pipeline reports a miss and asks to run ahead, the block copies the architectural register values, the branch history and the return-stack pointer into a shadow copy. It then enters runahead mode, in which the missing load's destination is poisoned.

While running ahead, every retiring write still updates the live register file. Each register also carries a poison (INV) bit. A result computed from a poisoned source, or flagged as poisoned by the producer, is poisoned itself. A result computed from clean sources makes its destination clean again. When the miss data comes back, a single pulse puts the shadow copy back into the live registers and clears every poison bit in the next cycle. At the same time, the saved history and stack pointer are offered to the predictor together with a one-cycle restore strobe.

Top module: `rh_ckpt_poison`

## Requirements
- R1: After reset the block is in normal mode, `restore_o` is 0, every poison bit is 0 and every register reads 0.
- R2: In normal mode a write with `wr_en_i` updates the register `wr_dest_i`, which reads back in the next cycle; poison bits stay 0 even when `wr_inv_i` is 1.
- R3: An entry request in normal mode sets `runahead_o` in the next cycle and poisons register `miss_dest_i`. The snapshot holds the register file including any write in that same cycle, together with `hist_i` and `ras_ptr_i`.
- R4: In runahead mode a write whose enabled source operand is poisoned, or that has `wr_inv_i` set, stores its data and poisons its destination in the next cycle.
- R5: In runahead mode a write whose enabled sources are all clean and whose `wr_inv_i` is 0 clears the destination's poison bit.
- R6: An entry request while already in runahead mode is ignored: no new snapshot is taken, `miss_dest_i` is not poisoned, and the mode does not change.
- R7: A `miss_ret_i` pulse in runahead mode causes the following, one cycle later. The register file equals the snapshot and all poison bits are 0. `runahead_o` is 0 and `restore_o` is 1 for exactly one cycle. `hist_restore_o` and `ras_restore_o` show the values captured at entry. A write in the exit cycle is discarded.
- R8: A `miss_ret_i` pulse in normal mode has no effect. When entry and return arrive together in normal mode, entry is taken.
- R9: A source operand whose enable is 0 never poisons the result, whatever the poison bit of the register it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_req_i | input | 1 | Request to start runahead on a long-latency miss |
| miss_dest_i | input | 5 | Destination register of the missing load |
| miss_ret_i | input | 1 | Pulse: the miss data has returned |
| wr_en_i | input | 1 | Retiring register write |
| wr_dest_i | input | 5 | Write destination |
| wr_data_i | input | 32 | Write data |
| src_a_i | input | 5 | First source register of the writing instruction |
| src_a_en_i | input | 1 | First source is used |
| src_b_i | input | 5 | Second source register |
| src_b_en_i | input | 1 | Second source is used |
| wr_inv_i | input | 1 | Producer marks its result as poisoned |
| hist_i | input | 16 | Current branch history |
| ras_ptr_i | input | 3 | Current return-stack pointer |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 32 | Live value of the addressed register |
| rd_inv_o | output | 1 | Poison bit of the addressed register |
| inv_vec_o | output | 32 | All poison bits, bit n for register n |
| runahead_o | output | 1 | Runahead mode active |
| restore_o | output | 1 | One-cycle strobe: checkpoint restored |
| hist_restore_o | output | 16 | Branch history saved at entry |
| ras_restore_o | output | 3 | Return-stack pointer saved at entry |

## Verification
The bench first writes a register in the same cycle as the entry request and checks that this value survives the restore. A design that snapshots the pre-write file would bring back a stale value. It issues a second entry request during runahead with a different history and destination. A design that does not ignore it would restore the wrong history or poison an extra register. It also covers a disabled source that names a poisoned register, a clean write that must heal a poisoned destination, and a write in the exit cycle that must be lost. Finally, it drives return and entry together in normal mode; a design that gives return priority there would stay out of runahead.

// File: rtl/rh_pkg.sv
package rh_pkg;

    typedef enum logic {
        RH_NORMAL = 1'b0,
        RH_AHEAD  = 1'b1
    } rh_mode_e;

endpackage

// File: rtl/rh_mode_ctrl.sv
module rh_mode_ctrl
    import rh_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enter_req_i,
    input  logic miss_ret_i,
    output logic active_o,
    output logic take_ckpt_o,
    output logic do_restore_o,
    output logic restore_pulse_o
);

    typedef struct packed {
        rh_mode_e mode;
        logic     pulse;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pulse   = 1'b0;
        take_ckpt_o  = (st_q.mode == RH_NORMAL) && enter_req_i;
        do_restore_o = (st_q.mode == RH_AHEAD) && miss_ret_i;
        if (take_ckpt_o) begin
            st_d.mode = RH_AHEAD;
        end
        if (do_restore_o) begin
            st_d.mode  = RH_NORMAL;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: RH_NORMAL, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o        = (st_q.mode == RH_AHEAD);
    assign restore_pulse_o = st_q.pulse;

endmodule

// File: rtl/rh_poison_track.sv
module rh_poison_track #(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            active_i,
    input  logic            take_ckpt_i,
    input  logic            do_restore_i,
    input  logic [AW-1:0]   miss_dest_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_dest_i,
    input  logic [AW-1:0]   src_a_i,
    input  logic            src_a_en_i,
    input  logic [AW-1:0]   src_b_i,
    input  logic            src_b_en_i,
    input  logic            wr_inv_i,
    output logic [NREG-1:0] inv_o
);

    typedef struct packed {
        logic [NREG-1:0] inv;
    } pois_t;

    pois_t           st_d, st_q;
    logic            src_poisoned;
    logic [NREG-1:0] bit_next;

    // Result poison: any enabled poisoned source, or producer-flagged
    assign src_poisoned = (src_a_en_i && st_q.inv[src_a_i])
                        || (src_b_en_i && st_q.inv[src_b_i])
                        || wr_inv_i;

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        logic hit_wr, hit_miss;
        assign hit_wr   = active_i && wr_en_i && (wr_dest_i == AW'(g));
        assign hit_miss = take_ckpt_i && (miss_dest_i == AW'(g));
        always_comb begin
            if (do_restore_i) begin
                bit_next[g] = 1'b0;
            end else if (hit_miss) begin
                bit_next[g] = 1'b1;
            end else if (hit_wr) begin
                bit_next[g] = src_poisoned;
            end else begin
                bit_next[g] = st_q.inv[g];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.inv = bit_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inv_o = st_q.inv;

endmodule

// File: rtl/rh_reg_ckpt.sv
module rh_reg_ckpt #(
    parameter int NREG   = 32,
    parameter int XLEN   = 32,
    parameter int HIST_W = 16,
    parameter int RAS_W  = 3,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              take_ckpt_i,
    input  logic              do_restore_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_dest_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic [HIST_W-1:0] hist_i,
    input  logic [RAS_W-1:0]  ras_ptr_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [XLEN-1:0]   rd_data_o,
    output logic [HIST_W-1:0] hist_saved_o,
    output logic [RAS_W-1:0]  ras_saved_o
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] live;
        logic [NREG-1:0][XLEN-1:0] shadow;
        logic [HIST_W-1:0]         hist;
        logic [RAS_W-1:0]          ras;
    } rf_t;

    rf_t             st_d, st_q;
    logic [NREG-1:0] wsel;

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wsel[g] = wr_en_i && (wr_dest_i == AW'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (do_restore_i) begin
                st_d.live[i] = st_q.shadow[i];
            end else if (wsel[i]) begin
                st_d.live[i] = wr_data_i;
            end
        end
        // Snapshot includes a write retiring in the entry cycle
        if (take_ckpt_i) begin
            st_d.shadow = st_d.live;
            st_d.hist   = hist_i;
            st_d.ras    = ras_ptr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o    = st_q.live[rd_addr_i];
    assign hist_saved_o = st_q.hist;
    assign ras_saved_o  = st_q.ras;

endmodule

// File: rtl/rh_ckpt_poison.sv
module rh_ckpt_poison #(
    parameter int NREG   = 32,
    parameter int XLEN   = 32,
    parameter int HIST_W = 16,
    parameter int RAS_W  = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     enter_req_i,
    input  logic [$clog2(NREG)-1:0]  miss_dest_i,
    input  logic                     miss_ret_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(NREG)-1:0]  wr_dest_i,
    input  logic [XLEN-1:0]          wr_data_i,
    input  logic [$clog2(NREG)-1:0]  src_a_i,
    input  logic                     src_a_en_i,
    input  logic [$clog2(NREG)-1:0]  src_b_i,
    input  logic                     src_b_en_i,
    input  logic                     wr_inv_i,
    input  logic [HIST_W-1:0]        hist_i,
    input  logic [RAS_W-1:0]         ras_ptr_i,
    input  logic [$clog2(NREG)-1:0]  rd_addr_i,
    output logic [XLEN-1:0]          rd_data_o,
    output logic                     rd_inv_o,
    output logic [NREG-1:0]          inv_vec_o,
    output logic                     runahead_o,
    output logic                     restore_o,
    output logic [HIST_W-1:0]        hist_restore_o,
    output logic [RAS_W-1:0]         ras_restore_o
);

    logic active, take_ckpt, do_restore;

    rh_mode_ctrl u_ctrl (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .enter_req_i     (enter_req_i),
        .miss_ret_i      (miss_ret_i),
        .active_o        (active),
        .take_ckpt_o     (take_ckpt),
        .do_restore_o    (do_restore),
        .restore_pulse_o (restore_o)
    );

    rh_poison_track #(.NREG(NREG)) u_pois (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .active_i     (active),
        .take_ckpt_i  (take_ckpt),
        .do_restore_i (do_restore),
        .miss_dest_i  (miss_dest_i),
        .wr_en_i      (wr_en_i),
        .wr_dest_i    (wr_dest_i),
        .src_a_i      (src_a_i),
        .src_a_en_i   (src_a_en_i),
        .src_b_i      (src_b_i),
        .src_b_en_i   (src_b_en_i),
        .wr_inv_i     (wr_inv_i),
        .inv_o        (inv_vec_o)
    );

    rh_reg_ckpt #(
        .NREG(NREG), .XLEN(XLEN), .HIST_W(HIST_W), .RAS_W(RAS_W)
    ) u_rf (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .take_ckpt_i  (take_ckpt),
        .do_restore_i (do_restore),
        .wr_en_i      (wr_en_i),
        .wr_dest_i    (wr_dest_i),
        .wr_data_i    (wr_data_i),
        .hist_i       (hist_i),
        .ras_ptr_i    (ras_ptr_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .hist_saved_o (hist_restore_o),
        .ras_saved_o  (ras_restore_o)
    );

    assign runahead_o = active;
    assign rd_inv_o   = inv_vec_o[rd_addr_i];

endmodule

// File: rtl/rh_ckpt_poison_chk.sv
module rh_ckpt_poison_chk #(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            enter_req_i,
    input logic [AW-1:0]   miss_dest_i,
    input logic            miss_ret_i,
    input logic            wr_en_i,
    input logic [AW-1:0]   wr_dest_i,
    input logic [AW-1:0]   src_a_i,
    input logic            src_a_en_i,
    input logic [NREG-1:0] inv_vec_o,
    input logic            runahead_o,
    input logic            restore_o
);

    // R2
    normal_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !runahead_o |-> inv_vec_o == '0);

    // R3
    entry_poison_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !runahead_o && enter_req_i |=> runahead_o && inv_vec_o[$past(miss_dest_i)]);

    // R4
    spread_poison_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        runahead_o && !miss_ret_i && wr_en_i && src_a_en_i && inv_vec_o[src_a_i]
        |=> inv_vec_o[$past(wr_dest_i)]);

    // R6
    reentry_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        runahead_o && enter_req_i && !miss_ret_i |=> runahead_o && !restore_o);

    // R7
    exit_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        runahead_o && miss_ret_i |=> !runahead_o && restore_o && inv_vec_o == '0);

    // R7
    restore_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_o |=> !restore_o);

    // R8
    stray_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !runahead_o && miss_ret_i && !enter_req_i |=> !runahead_o && !restore_o);

endmodule

bind rh_ckpt_poison rh_ckpt_poison_chk #(.NREG(NREG)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enter_req_i (enter_req_i),
    .miss_dest_i (miss_dest_i),
    .miss_ret_i  (miss_ret_i),
    .wr_en_i     (wr_en_i),
    .wr_dest_i   (wr_dest_i),
    .src_a_i     (src_a_i),
    .src_a_en_i  (src_a_en_i),
    .inv_vec_o   (inv_vec_o),
    .runahead_o  (runahead_o),
    .restore_o   (restore_o)
);

// File: tb/rh_ckpt_poison_tb_top.sv
module rh_ckpt_poison_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req, miss_ret, wr_en, src_a_en, src_b_en, wr_inv;
    logic [4:0]  miss_dest, wr_dest, src_a, src_b, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [15:0] hist, hist_rst;
    logic [2:0]  ras, ras_rst;
    logic [31:0] inv_vec;
    logic        rd_inv, runahead, restore;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rh_ckpt_poison dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enter_req_i(enter_req), .miss_dest_i(miss_dest),
        .miss_ret_i(miss_ret), .wr_en_i(wr_en), .wr_dest_i(wr_dest), .wr_data_i(wr_data),
        .src_a_i(src_a), .src_a_en_i(src_a_en), .src_b_i(src_b), .src_b_en_i(src_b_en),
        .wr_inv_i(wr_inv), .hist_i(hist), .ras_ptr_i(ras), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .rd_inv_o(rd_inv), .inv_vec_o(inv_vec), .runahead_o(runahead),
        .restore_o(restore), .hist_restore_o(hist_rst), .ras_restore_o(ras_rst)
    );

    typedef struct packed {
        logic        enter;
        logic        ret;
        logic        we;
        logic [4:0]  dest;
        logic [31:0] data;
        logic [4:0]  sa;
        logic        sa_en;
        logic [4:0]  sb;
        logic        sb_en;
        logic        winv;
        logic [4:0]  mdest;
        logic [15:0] hist;
        logic [2:0]  ras;
        logic [4:0]  rd;
        logic        x_ra;
        logic        x_rest;
        logic [31:0] x_data;
        logic        x_inv;
        logic [15:0] x_hist;
        logic [2:0]  x_ras;
        logic [3:0]  req;
    } vec_t;

    // enter ret we dest data sa sa_en sb sb_en winv mdest hist ras rd | ra rest data inv hist ras req
    localparam vec_t VECS [NV] = '{
        // R2 plain write
        '{1'b0,1'b0,1'b1,5'd1,32'h11,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd1, 1'b0,1'b0,32'h11,1'b0,16'h0,3'd0,4'd2},
        // R2 producer poison ignored in normal mode
        '{1'b0,1'b0,1'b1,5'd2,32'h22,5'd0,1'b0,5'd0,1'b0,1'b1,5'd0,16'h0,3'd0,5'd2, 1'b0,1'b0,32'h22,1'b0,16'h0,3'd0,4'd2},
        // R8 stray return
        '{1'b0,1'b1,1'b0,5'd0,32'h0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd1, 1'b0,1'b0,32'h11,1'b0,16'h0,3'd0,4'd8},
        // R3 entry, miss dest r5, same-cycle write r3
        '{1'b1,1'b0,1'b1,5'd3,32'h33,5'd0,1'b0,5'd0,1'b0,1'b0,5'd5,16'hA5A5,3'd3,5'd5, 1'b1,1'b0,32'h0,1'b1,16'h0,3'd0,4'd3},
        // R4 poisoned source r5 spreads to r6
        '{1'b0,1'b0,1'b1,5'd6,32'h66,5'd5,1'b1,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd6, 1'b1,1'b0,32'h66,1'b1,16'h0,3'd0,4'd4},
        // R9 disabled source naming r5 does not poison r7
        '{1'b0,1'b0,1'b1,5'd7,32'h77,5'd5,1'b0,5'd1,1'b1,1'b0,5'd0,16'h0,3'd0,5'd7, 1'b1,1'b0,32'h77,1'b0,16'h0,3'd0,4'd9},
        // R4 producer-flagged poison on r1
        '{1'b0,1'b0,1'b1,5'd1,32'h99,5'd0,1'b0,5'd0,1'b0,1'b1,5'd0,16'h0,3'd0,5'd1, 1'b1,1'b0,32'h99,1'b1,16'h0,3'd0,4'd4},
        // R5 clean write heals r5
        '{1'b0,1'b0,1'b1,5'd5,32'h55,5'd2,1'b1,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd5, 1'b1,1'b0,32'h55,1'b0,16'h0,3'd0,4'd5},
        // R6 re-entry ignored
        '{1'b1,1'b0,1'b0,5'd0,32'h0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd8,16'hFFFF,3'd7,5'd8, 1'b1,1'b0,32'h0,1'b0,16'h0,3'd0,4'd6},
        // R7 exit; write to r3 in exit cycle is lost
        '{1'b0,1'b1,1'b1,5'd3,32'hEE,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd3, 1'b0,1'b1,32'h33,1'b0,16'hA5A5,3'd3,4'd7},
        // R7 strobe drops, r1 back to checkpointed value
        '{1'b0,1'b0,1'b0,5'd0,32'h0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,16'h0,3'd0,5'd1, 1'b0,1'b0,32'h11,1'b0,16'h0,3'd0,4'd7}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        enter_req = 0; miss_ret = 0; wr_en = 0; wr_dest = 0; wr_data = 0;
        src_a = 0; src_a_en = 0; src_b = 0; src_b_en = 0; wr_inv = 0;
        miss_dest = 0; hist = 0; ras = 0; rd_addr = 0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "runahead", {31'd0, runahead}, 32'd0);
        chk("R1", "restore", {31'd0, restore}, 32'd0);
        chk("R1", "inv_vec", inv_vec, 32'd0);
        chk("R1", "rd_data", rd_data, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            enter_req = VECS[i].enter; miss_ret = VECS[i].ret; wr_en = VECS[i].we;
            wr_dest = VECS[i].dest; wr_data = VECS[i].data; src_a = VECS[i].sa;
            src_a_en = VECS[i].sa_en; src_b = VECS[i].sb; src_b_en = VECS[i].sb_en;
            wr_inv = VECS[i].winv; miss_dest = VECS[i].mdest; hist = VECS[i].hist;
            ras = VECS[i].ras; rd_addr = VECS[i].rd;
            @(negedge clk);
            chk(tag, "runahead", {31'd0, runahead}, {31'd0, VECS[i].x_ra});
            chk(tag, "restore", {31'd0, restore}, {31'd0, VECS[i].x_rest});
            chk(tag, "rd_data", rd_data, VECS[i].x_data);
            chk(tag, "rd_inv", {31'd0, rd_inv}, {31'd0, VECS[i].x_inv});
            if (VECS[i].x_rest) begin
                chk(tag, "hist_restore", {16'd0, hist_rst}, {16'd0, VECS[i].x_hist});
                chk(tag, "ras_restore", {29'd0, ras_rst}, {29'd0, VECS[i].x_ras});
                chk(tag, "inv_vec", inv_vec, 32'd0);
            end
        end
        idle();

        // R6 no stray poison on r8 after ignored re-entry (post restore read)
        rd_addr = 5'd8;
        @(negedge clk);
        chk("R6", "r8 data", rd_data, 32'd0);

        // R7 register written only in runahead is rolled back
        rd_addr = 5'd6;
        @(negedge clk);
        chk("R7", "r6 rolled back", rd_data, 32'd0);

        // R8 entry and return together in normal mode: entry wins
        enter_req = 1; miss_ret = 1; miss_dest = 5'd9; hist = 16'h1234; ras = 3'd5; rd_addr = 5'd9;
        @(negedge clk);
        chk("R8", "runahead", {31'd0, runahead}, 32'd1);
        chk("R8", "r9 poisoned", {31'd0, rd_inv}, 32'd1);
        idle();
        miss_ret = 1;
        @(negedge clk);
        miss_ret = 0;
        chk("R7", "hist_restore", {16'd0, hist_rst}, 32'h1234);
        chk("R7", "ras_restore", {29'd0, ras_rst}, 32'd5);
        chk("R7", "inv_vec", inv_vec, 32'd0);
        @(negedge clk);
        chk("R7", "restore pulse ends", {31'd0, restore}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (R1..) actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule